// File: doc/BRIEF.md
# Packed Lane Add/Subtract Unit

This unit treats two 64-bit operands as groups of equal-width lanes and adds or subtracts them lane by lane. A lane can be 8, 16 or 32 bits wide. Each lane result follows one of three overflow policies. In wraparound mode the lane keeps its low bits and drops the carry or borrow. In signed saturation mode the result is clamped to the signed range of the lane. In unsigned saturation mode the result is clamped to the unsigned range of the lane.

The result is always the destination operand combined with the source operand, so subtraction gives destination minus source. A combination the datapath does not support raises a flag and forces the result to zero. The result and the flag are registered, so they appear one clock after the inputs.

Top module: `psat_addsub`

## Requirements
- R1: `size_i` selects the lane width: 0 = 8-bit lanes (eight lanes), 1 = 16-bit lanes (four lanes), 2 = 32-bit lanes (two lanes). Lane k occupies bits [k*w +: w].
- R2: When `mode_i` = 0 (wraparound), each lane keeps the low w bits of its sum or difference and drops the carry. For example, 8'h02 + 8'hFF gives 8'h01.
- R3: When `mode_i` = 1 (signed saturation) and the lanes are 8 bits wide, each lane result is clamped to the range 8'h80 to 8'h7F.
- R4: When `mode_i` = 2 (unsigned saturation) and the lanes are 8 bits wide, each lane result is clamped to the range 8'h00 to 8'hFF.
- R5: When `mode_i` = 1 and the lanes are 16 bits wide, each lane result is clamped to the range 16'h8000 to 16'h7FFF.
- R6: When `mode_i` = 2 and the lanes are 16 bits wide, each lane result is clamped to the range 16'h0000 to 16'hFFFF.
- R7: `op_i` = 0 adds and `op_i` = 1 subtracts, computing destination minus source. An unsigned-saturating subtraction that would go below zero gives 0.
- R8: A carry or borrow never passes from one lane into the next.
- R9: `illegal_o` is 1 and `result_o` is 0 in any of these cases: 32-bit lanes with a saturating mode, `size_i` = 3, or `mode_i` = 3. Otherwise `illegal_o` is 0.
- R10: `result_o` and `illegal_o` are registered one clock after the inputs. While `rst_ni` is low, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dst_i | input | 64 | Destination operand (left-hand side) |
| src_i | input | 64 | Source operand (right-hand side) |
| op_i | input | 1 | 0 = add, 1 = subtract |
| size_i | input | 2 | Lane width select |
| mode_i | input | 2 | Overflow policy select |
| result_o | output | 64 | Registered lane-wise result |
| illegal_o | output | 1 | Registered flag for an unsupported combination |

## Verification
The unit has only one register stage, so any fault shows at the ports on the very next clock. A wrong lane mux or a carry leaking into the next lane changes the neighbouring lane bits of `result_o` in that cycle. A wrong overflow policy shows when a lane sits at or just past its limit: the result either wraps or sticks at a bound when it should not. The scoreboard therefore drives operands at the edge of each lane range in every mode. It also runs a stream of mixed operations back to back, so that a stale register or a wrong latency shows up as a mismatch on the very next item.

// File: rtl/psat_pkg.sv
package psat_pkg;
  localparam int unsigned DATA_W = 64;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } psat_size_e;

  typedef enum logic [1:0] {
    MD_WRAP = 2'd0,
    MD_SSAT = 2'd1,
    MD_USAT = 2'd2,
    MD_RSVD = 2'd3
  } psat_mode_e;

  localparam int unsigned NUM_SIZES = 3;
endpackage

// File: rtl/psat_lane.sv
module psat_lane #(
  parameter int unsigned W = 8
) (
  input  logic                  [W-1:0] a_i,
  input  logic                  [W-1:0] b_i,
  input  logic                          sub_i,
  input  psat_pkg::psat_mode_e          mode_i,
  output logic                  [W-1:0] y_o
);
  import psat_pkg::*;

  logic [W:0]   ext;
  logic [W-1:0] raw;
  logic         ucarry;
  logic         sovf;
  logic [W-1:0] smax, smin;

  assign smax = {1'b0, {(W-1){1'b1}}};
  assign smin = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    ext    = sub_i ? ({1'b0, a_i} - {1'b0, b_i}) : ({1'b0, a_i} + {1'b0, b_i});
    raw    = ext[W-1:0];
    ucarry = ext[W];
    // signed overflow: operand signs allow it and result sign left a's sign
    sovf   = ((a_i[W-1] ^ b_i[W-1]) == sub_i) && (raw[W-1] != a_i[W-1]);
    unique case (mode_i)
      MD_SSAT: y_o = sovf ? (a_i[W-1] ? smin : smax) : raw;
      MD_USAT: y_o = ucarry ? (sub_i ? '0 : '1) : raw;
      default: y_o = raw;
    endcase
  end
endmodule

// File: rtl/psat_slice.sv
module psat_slice #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 8
) (
  input  logic                  [DATA_W-1:0] a_i,
  input  logic                  [DATA_W-1:0] b_i,
  input  logic                               sub_i,
  input  psat_pkg::psat_mode_e               mode_i,
  output logic                  [DATA_W-1:0] y_o
);
  localparam int unsigned NLANE = DATA_W / LANE_W;

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    psat_lane #(.W(LANE_W)) u_lane (
      .a_i   (a_i[k*LANE_W +: LANE_W]),
      .b_i   (b_i[k*LANE_W +: LANE_W]),
      .sub_i (sub_i),
      .mode_i(mode_i),
      .y_o   (y_o[k*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/psat_addsub.sv
module psat_addsub #(
  parameter int unsigned DATA_W = psat_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic              op_i,
  input  logic [1:0]        size_i,
  input  logic [1:0]        mode_i,
  output logic [DATA_W-1:0] result_o,
  output logic              illegal_o
);
  import psat_pkg::*;

  psat_size_e  size;
  psat_mode_e  mode;
  logic [DATA_W-1:0] slice_y [NUM_SIZES];
  logic [DATA_W-1:0] sel_y;
  logic              bad;

  assign size = psat_size_e'(size_i);
  assign mode = psat_mode_e'(mode_i);

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    psat_slice #(.DATA_W(DATA_W), .LANE_W(8 << g)) u_slice (
      .a_i   (dst_i),
      .b_i   (src_i),
      .sub_i (op_i),
      .mode_i(mode),
      .y_o   (slice_y[g])
    );
  end

  always_comb begin
    bad = (size == SZ_RSVD) || (mode == MD_RSVD) ||
          ((size == SZ_DWORD) && (mode != MD_WRAP));
    unique case (size)
      SZ_BYTE:  sel_y = slice_y[0];
      SZ_WORD:  sel_y = slice_y[1];
      SZ_DWORD: sel_y = slice_y[2];
      default:  sel_y = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      illegal_o <= 1'b0;
    end else begin
      result_o  <= bad ? '0 : sel_y;
      illegal_o <= bad;
    end
  end
endmodule

// File: rtl/psat_addsub_chk.sv
module psat_addsub_chk #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] dst_i,
  input logic [DATA_W-1:0] src_i,
  input logic              op_i,
  input logic [1:0]        size_i,
  input logic [1:0]        mode_i,
  input logic [DATA_W-1:0] result_o,
  input logic              illegal_o
);
  logic in_bad;
  assign in_bad = (size_i == 2'd3) || (mode_i == 2'd3) ||
                  ((size_i == 2'd2) && (mode_i != 2'd0));

  // true when every lane of x is >= the matching lane of y (unsigned)
  function automatic logic lanes_ge(input logic [DATA_W-1:0] x,
                                    input logic [DATA_W-1:0] y,
                                    input logic [1:0] sz);
    int unsigned w;
    logic ok;
    ok = 1'b1;
    w  = 8 << sz;
    for (int i = 0; i < DATA_W / 8; i++) begin
      if (i < int'(DATA_W / w)) begin
        if (((x >> (i * w)) & ((64'd1 << w) - 64'd1)) <
            ((y >> (i * w)) & ((64'd1 << w) - 64'd1)))
          ok = 1'b0;
      end
    end
    return ok;
  endfunction

  a_r9_illegal_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_bad |=> (illegal_o && result_o == '0));

  a_r9_legal_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_bad |=> !illegal_o);

  a_r2_add_zero_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_bad && mode_i == 2'd0 && !op_i && src_i == '0) |=> result_o == $past(dst_i));

  a_r7_self_sub_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_bad && op_i && dst_i == src_i) |=> result_o == '0);

  a_r4_usat_add_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_bad && mode_i == 2'd2 && !op_i) |=> lanes_ge(result_o, $past(dst_i), $past(size_i)));

  a_r7_usat_sub_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_bad && mode_i == 2'd2 && op_i) |=> lanes_ge($past(dst_i), result_o, $past(size_i)));
endmodule

bind psat_addsub psat_addsub_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/psat_addsub_bench.sv
module psat_addsub_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] dst = '0, src = '0;
  logic        op = 1'b0;
  logic [1:0]  size = '0, mode = '0;
  logic [63:0] result;
  logic        illegal;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [63:0] res;
    logic        ill;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;  // 50 MHz

  psat_addsub u_psat_addsub (
    .clk_i(clk), .rst_ni(rst_n), .dst_i(dst), .src_i(src), .op_i(op),
    .size_i(size), .mode_i(mode), .result_o(result), .illegal_o(illegal)
  );

  function automatic void model(input logic [63:0] d, s, input logic sub,
                                input logic [1:0] sz, md,
                                output logic [63:0] r, output logic ill);
    longint one, m, ua, ub, sa, sb, v, lo, hi;
    int w;
    ill = (sz == 2'd3) || (md == 2'd3) || (sz == 2'd2 && md != 2'd0);
    r = '0;
    if (ill) return;
    one = 1;
    w = 8 << sz;
    m = (one << w) - 1;
    for (int i = 0; i < 64 / w; i++) begin
      ua = longint'(d >> (i * w)) & m;
      ub = longint'(s >> (i * w)) & m;
      if (md == 2'd1) begin
        sa = ((ua >> (w - 1)) & 1) != 0 ? ua - (one << w) : ua;
        sb = ((ub >> (w - 1)) & 1) != 0 ? ub - (one << w) : ub;
        v  = sub ? sa - sb : sa + sb;
        lo = -(one << (w - 1));
        hi = (one << (w - 1)) - 1;
        if (v < lo) v = lo;
        if (v > hi) v = hi;
      end else begin
        v = sub ? ua - ub : ua + ub;
        if (md == 2'd2) begin
          if (v < 0) v = 0;
          if (v > m) v = m;
        end
      end
      r = r | (64'(v & m) << (i * w));
    end
  endfunction

  task automatic drive(input logic [63:0] d, s, input logic sub,
                       input logic [1:0] sz, md, input string tag);
    exp_t e;
    @(negedge clk);
    dst = d; src = s; op = sub; size = sz; mode = md;
    model(d, s, sub, sz, md, e.res, e.ill);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic check(input string tag, input logic [63:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: one result per clock, sampled a quarter period after the edge
  initial forever begin
    @(posedge clk);
    #5;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check({e.tag, " result"}, result, e.res);
      check({e.tag, " illegal"}, {63'd0, illegal}, {63'd0, e.ill});
    end
  end

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset result", result, 64'd0);
    check("R10 reset illegal", {63'd0, illegal}, 64'd0);
    rst_n = 1'b1;

    // R2: wraparound, example value
    drive(64'h0202_0202_0202_0202, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 2'd0, 2'd0, "R2 byte wrap");
    drive(64'h8000_7FFF_0001_FFFF, 64'h8000_0001_FFFF_0002, 1'b0, 2'd1, 2'd0, "R2 word wrap");
    // R1: lane widths
    drive(64'h1234_5678_9ABC_DEF0, 64'h0F0F_0F0F_1111_1111, 1'b0, 2'd2, 2'd0, "R1 dword add");
    drive(64'h1234_5678_9ABC_DEF0, 64'h0F0F_0F0F_1111_1111, 1'b1, 2'd1, 2'd0, "R1 word sub");
    // R3
    drive(64'h7F7F_8080_7F00_8001, 64'h0101_0101_8101_0102, 1'b0, 2'd0, 2'd1, "R3 byte ssat add");
    drive(64'h8080_7F7F_0080_7F00, 64'h0101_FFFF_7F01_8081, 1'b1, 2'd0, 2'd1, "R3 byte ssat sub");
    // R4
    drive(64'hF0FF_0001_80FE_7F00, 64'h2001_FF00_8001_8000, 1'b0, 2'd0, 2'd2, "R4 byte usat add");
    // R5
    drive(64'h7FFF_8000_7FFE_0000, 64'h0001_FFFF_0001_8000, 1'b0, 2'd1, 2'd1, "R5 word ssat add");
    drive(64'h8000_7FFF_0000_1234, 64'h0001_FFFF_8000_1234, 1'b1, 2'd1, 2'd1, "R5 word ssat sub");
    // R6
    drive(64'hFFF0_FFFF_8000_0001, 64'h0020_0001_8000_FFFE, 1'b0, 2'd1, 2'd2, "R6 word usat add");
    // R7
    drive(64'h0010_2000_00FF_0000, 64'h0020_1000_0100_0001, 1'b1, 2'd1, 2'd2, "R7 word usat sub");
    drive(64'h1020_3040_5060_7080, 64'h2010_4030_6050_8070, 1'b1, 2'd0, 2'd2, "R7 byte usat sub");
    drive(64'h0000_0001_0000_0005, 64'h0000_0002_0000_0003, 1'b1, 2'd2, 2'd0, "R7 dword wrap sub");
    // R8: no carry into the neighbouring lane
    drive(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 1'b0, 2'd0, 2'd0, "R8 byte carry");
    drive(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 1'b0, 2'd2, 2'd0, "R8 dword carry");
    drive(64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 1'b1, 2'd1, 2'd0, "R8 word borrow");
    // R9
    drive(64'h7FFF_FFFF_0000_0001, 64'h0000_0001_0000_0001, 1'b0, 2'd2, 2'd1, "R9 dword ssat");
    drive(64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222, 1'b0, 2'd2, 2'd2, "R9 dword usat");
    drive(64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222, 1'b0, 2'd3, 2'd0, "R9 size rsvd");
    drive(64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222, 1'b1, 2'd0, 2'd3, "R9 mode rsvd");
    // R10: back-to-back mixed stream, one result per cycle
    for (int i = 0; i < 400; i++) begin
      logic [1:0] sz, md;
      sz = 2'($urandom_range(0, 3));
      md = 2'($urandom_range(0, 3));
      drive({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), sz, md, "R10 stream");
    end
    repeat (3) @(negedge clk);
    check("R10 queue drained", 64'(q.size()), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule